// File: doc/BRIEF.md
# Interleaved DMA Channel Address Sequencer

This block produces the memory address stream for a single DMA channel working in linear or interleave mode. Software loads four registers through a plain write port: a control word holding the mode and the start bit, the starting memory address, the number of 16-byte quadwords to move, and a pair giving the burst length and the skip distance. Setting the start bit launches the transfer. The block then offers one 16-byte-aligned address for each quadword the datapath accepts.

There are no hidden working copies. The address and count registers that software reads back are the live counters, so they advance during the transfer. In interleave mode the address jumps ahead by a programmed number of quadwords after each burst of a programmed length. When the count reaches zero the busy flag drops and a single-cycle done pulse is sent to the interrupt logic.

The address stream uses valid/ready. `addr_valid` stays high for as long as the channel is busy. While `addr_ready` is low, `addr_data` stays unchanged. A quadword counts as accepted only in a cycle where valid and ready are both high. The consumer may hold ready low for any number of cycles.

Top module: `dma_ilv_seq`

## Requirements
- R1: After reset the address, count, skip pair and control registers all read zero, and `addr_valid` and `done` are low.
- R2: A write with `wr_sel` set to 0 loads the control register and stores the mode from data bits 3:2 (0 linear, 1 chain, 2 interleave, 3 reserved). `wr_sel` 1 loads the address, and bits 3:0 always read back as zero. `wr_sel` 2 loads the count from bits 15:0. `wr_sel` 3 loads the skip distance M from bits 7:0 and the burst length N from bits 23:16. In the readback, mode appears at bits 3:2 and busy at bit 8.
- R3: A control write with bit 8 set, made while idle with a nonzero count, sets busy in the next cycle. From then on `addr_valid` is high and `addr_data` shows the address register.
- R4: While `addr_valid` is high and `addr_ready` is low, `addr_data` and all register readbacks hold their values. Exactly one quadword is consumed per cycle in which valid and ready are both high.
- R5: Each accepted quadword adds 16 to the address and subtracts 1 from the count. Address bit 31, the memory select, never changes.
- R6: The accepted quadword that brings the count to zero clears busy. `done` is high for exactly one cycle after that edge and is low at all other times.
- R7: A start with a count of zero never raises `addr_valid` and gives a single `done` pulse in the following cycle.
- R8: In mode 2 with N nonzero, the accepted quadword that ends each group of N also adds 16×M to the address, and the count is not touched beyond its normal decrement. With N equal to zero, or in any mode other than 2, the address advances linearly.
- R9: When the final quadword of the transfer also ends a group, no skip is added.
- R10: Writes to any of the four registers are ignored while busy.
- R11: The address increments wrap within bits 30:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 address, 2 count, 3 skip pair |
| wr_data | input | 32 | Register write data |
| addr_valid | output | 1 | Address stream valid (equals busy) |
| addr_ready | input | 1 | Address stream ready from the datapath |
| addr_data | output | 32 | Current quadword address |
| done | output | 1 | One-cycle completion pulse |
| ctrl_rd | output | 32 | Control readback: mode at bits 3:2, busy at bit 8 |
| madr_rd | output | 32 | Live address register |
| qwc_rd | output | 16 | Live quadword count |
| sqwc_rd | output | 32 | Skip pair: M at bits 7:0, N at bits 23:16 |

## Verification
Two updates can land on the same accepted quadword: the ordinary 16-byte advance with its count decrement, and the interleave skip at a group boundary. The harder case is when that boundary is also the last quadword. The bench sets up both situations. A count of 7 with N=2 makes every group end on a non-final quadword, while a count of 6 with N=2 makes the last group end exactly on the final quadword. In both runs `addr_ready` is toggled pseudo-randomly, so the boundaries fall both on stalled cycles and on back-to-back accepts. A behavioural model compares address, count, busy and done on every cycle, and the final address must show the skip counts of R8 and R9.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    MODE_LINEAR     = 2'd0,
    MODE_CHAIN      = 2'd1,
    MODE_INTERLEAVE = 2'd2,
    MODE_RSVD       = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_SKIP  = 2'd3
  } reg_sel_e;

  localparam int START_BIT = 8;
  localparam int MODE_LSB  = 2;
  localparam int QW_SHIFT  = 4;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int GRP_W  = 8,
  localparam int QW_W  = ADDR_W - QW_SHIFT - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             lock,
  input  logic             adv,
  input  logic [QW_W-1:0]  adv_qidx,
  output xfer_mode_e       mode,
  output logic             mem_sel,
  output logic [QW_W-1:0]  qidx,
  output logic [CNT_W-1:0] count,
  output logic [GRP_W-1:0] grp_len,
  output logic [GRP_W-1:0] skip_len
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_LINEAR;
      mem_sel  <= 1'b0;
      qidx     <= '0;
      count    <= '0;
      grp_len  <= '0;
      skip_len <= '0;
    end else if (wr_en && !lock) begin
      case (reg_sel_e'(wr_sel))
        SEL_CTRL:  mode <= xfer_mode_e'(wr_data[MODE_LSB +: 2]);
        SEL_ADDR: begin
          mem_sel <= wr_data[ADDR_W-1];
          qidx    <= wr_data[QW_SHIFT +: QW_W];
        end
        SEL_COUNT: count <= wr_data[CNT_W-1:0];
        default: begin
          skip_len <= wr_data[GRP_W-1:0];
          grp_len  <= wr_data[16 +: GRP_W];
        end
      endcase
    end else if (adv) begin
      qidx  <= adv_qidx;
      count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dma_seq_group.sv
module dma_seq_group #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat,
  input  logic             enable,
  input  logic [GRP_W-1:0] grp_len,
  output logic             at_end
);
  logic [GRP_W-1:0] pos;

  assign at_end = enable && (grp_len != '0) && (pos == grp_len - GRP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) pos <= '0;
    else if (beat)       pos <= at_end ? '0 : pos + GRP_W'(1);
  end
endmodule

// File: rtl/dma_seq_step.sv
module dma_seq_step #(
  parameter int QW_W  = 27,
  parameter int GRP_W = 8
) (
  input  logic [QW_W-1:0]  qidx,
  input  logic [GRP_W-1:0] skip_len,
  input  logic             apply_skip,
  output logic [QW_W-1:0]  next_qidx
);
  logic [QW_W-1:0] extra;

  always_comb begin
    extra     = apply_skip ? QW_W'(skip_len) : '0;
    next_qidx = qidx + QW_W'(1) + extra;
  end
endmodule

// File: rtl/dma_ilv_seq.sv
module dma_ilv_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int GRP_W  = 8,
  localparam int QW_W  = ADDR_W - QW_SHIFT - 1,
  localparam int PAD_W = 16 - GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_data,
  output logic              done,
  output logic [31:0]       ctrl_rd,
  output logic [ADDR_W-1:0] madr_rd,
  output logic [CNT_W-1:0]  qwc_rd,
  output logic [31:0]       sqwc_rd
);
  logic             busy_q, done_q;
  xfer_mode_e       mode;
  logic             mem_sel;
  logic [QW_W-1:0]  qidx, next_qidx;
  logic [CNT_W-1:0] count;
  logic [GRP_W-1:0] grp_len, skip_len;
  logic             beat, start_req, last_beat, grp_end, apply_skip;

  assign beat       = busy_q && addr_ready;
  assign start_req  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL) && wr_data[START_BIT] && !busy_q;
  assign last_beat  = beat && (count == CNT_W'(1));
  assign apply_skip = grp_end && (count != CNT_W'(1));

  dma_seq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .GRP_W(GRP_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
    .lock(busy_q), .adv(beat), .adv_qidx(next_qidx),
    .mode, .mem_sel, .qidx, .count, .grp_len, .skip_len
  );

  dma_seq_group #(.GRP_W(GRP_W)) u_group (
    .clk, .rst_n, .clear(start_req), .beat,
    .enable(mode == MODE_INTERLEAVE), .grp_len, .at_end(grp_end)
  );

  dma_seq_step #(.QW_W(QW_W), .GRP_W(GRP_W)) u_step (
    .qidx, .skip_len, .apply_skip, .next_qidx
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_beat || (start_req && count == '0);
      if (start_req && count != '0) busy_q <= 1'b1;
      else if (last_beat)           busy_q <= 1'b0;
    end
  end

  assign addr_valid = busy_q;
  assign addr_data  = {mem_sel, qidx, {QW_SHIFT{1'b0}}};
  assign done       = done_q;
  assign madr_rd    = addr_data;
  assign qwc_rd     = count;
  assign ctrl_rd    = {23'd0, busy_q, 4'd0, mode, 2'd0};
  assign sqwc_rd    = {{PAD_W{1'b0}}, grp_len, {PAD_W{1'b0}}, skip_len};
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_data,
  input logic              done,
  input logic [31:0]       ctrl_rd,
  input logic [ADDR_W-1:0] madr_rd,
  input logic [CNT_W-1:0]  qwc_rd,
  input logic [31:0]       sqwc_rd
);
  a_r3_valid_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid == ctrl_rd[8]);

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_data) && $stable(qwc_rd));

  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> addr_data[3:0] == 4'd0);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready |=> qwc_rd == $past(qwc_rd) - CNT_W'(1));

  a_r5_select_kept: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> madr_rd[ADDR_W-1] == $past(madr_rd[ADDR_W-1]));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid && qwc_rd == '0);

  a_r10_skip_locked: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> $stable(sqwc_rd));
endmodule

bind dma_ilv_seq dma_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr_data(addr_data), .done(done), .ctrl_rd(ctrl_rd), .madr_rd(madr_rd),
  .qwc_rd(qwc_rd), .sqwc_rd(sqwc_rd)
);

// File: tb/dma_ilv_seq_tb.sv
module dma_ilv_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        addr_valid, addr_ready, done;
  logic [31:0] addr_data, ctrl_rd, madr_rd, sqwc_rd;
  logic [15:0] qwc_rd;

  always #5 clk = ~clk;

  dma_ilv_seq u_dut (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .addr_valid, .addr_ready,
    .addr_data, .done, .ctrl_rd, .madr_rd, .qwc_rd, .sqwc_rd
  );

  int checks = 0, errors = 0;
  int done_seen = 0, valid_seen = 0;
  logic rdy_rand = 1'b0, rdy_fix = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference
  logic [31:0] m_addr;
  int m_qwc, m_mode, m_n, m_m, m_pos;
  logic m_busy, m_done;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_qwc = 0; m_mode = 0; m_n = 0; m_m = 0; m_pos = 0;
      m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy && addr_ready) begin
        logic [26:0] q;
        int adv;
        logic skip;
        skip = (m_mode == 2) && (m_n != 0) && (m_pos == m_n - 1);
        adv  = 1 + ((skip && m_qwc != 1) ? m_m : 0);
        q = m_addr[30:4] + 27'(adv);
        m_addr = {m_addr[31], q, 4'd0};
        m_pos = skip ? 0 : m_pos + 1;
        m_qwc--;
        if (m_qwc == 0) begin m_busy = 0; m_done = 1; end
      end else if (wr_en && !m_busy) begin
        case (wr_sel)
          2'd0: begin
            m_mode = wr_data[3:2];
            if (wr_data[8]) begin
              m_pos = 0;
              if (m_qwc == 0) m_done = 1; else m_busy = 1;
            end
          end
          2'd1: m_addr = {wr_data[31:4], 4'd0};
          2'd2: m_qwc = wr_data[15:0];
          default: begin m_m = wr_data[7:0]; m_n = wr_data[23:16]; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 valid", {31'd0, addr_valid}, {31'd0, m_busy});
      if (m_busy) chk("R5 addr", addr_data, m_addr);
      chk("R5 madr", madr_rd, m_addr);
      chk("R5 count", {16'd0, qwc_rd}, 32'(m_qwc));
      chk("R3 ctrl", ctrl_rd, {23'd0, m_busy, 4'd0, 2'(m_mode), 2'd0});
      chk("R6 done", {31'd0, done}, {31'd0, m_done});
      if (done) done_seen++;
      if (addr_valid) valid_seen++;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    addr_ready = rdy_rand ? lfsr[0] : rdy_fix;
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && ctrl_rd[8]; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    addr_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 madr", madr_rd, 32'h0);
    chk("R1 count", {16'd0, qwc_rd}, 32'h0);
    chk("R1 skip", sqwc_rd, 32'h0);
    chk("R1 ctrl", ctrl_rd, 32'h0);
    chk("R1 valid_done", {30'd0, addr_valid, done}, 32'h0);

    // R2 register loads
    wr(2'd1, 32'h1234_5678);
    chk("R2 addr align", madr_rd, 32'h1234_5670);
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R2 skip fields", sqwc_rd, 32'h00FF_00FF);
    wr(2'd0, 32'h0000_000C);
    chk("R2 mode", ctrl_rd, 32'h0000_000C);
    wr(2'd2, 32'h0001_0005);
    chk("R2 count", {16'd0, qwc_rd}, 32'd5);

    // R3/R5/R6 linear transfer
    wr(2'd1, 32'h0000_0100);
    wr(2'd0, 32'h0000_0100);
    chk("R3 busy", {31'd0, ctrl_rd[8]}, 32'd1);
    wait_idle();
    chk("R5 linear end", madr_rd, 32'h0000_0150);
    chk("R6 count zero", {16'd0, qwc_rd}, 32'd0);

    // R7 zero-count start
    begin
      int d0, v0;
      d0 = done_seen; v0 = valid_seen;
      wr(2'd0, 32'h0000_0100);
      @(negedge clk);
      chk("R7 done once", 32'(done_seen - d0), 32'd1);
      chk("R7 no valid", 32'(valid_seen - v0), 32'd0);
    end

    // R8 interleave with stalls, N=2 M=3, count 7
    rdy_rand = 1'b1;
    wr(2'd1, 32'h8000_0000);
    wr(2'd2, 32'd7);
    wr(2'd3, 32'h0002_0003);
    wr(2'd0, 32'h0000_0108);
    wait_idle();
    chk("R8 interleave end", madr_rd, 32'h8000_0100);

    // R9 final quadword on group boundary, count 6
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd6);
    wr(2'd0, 32'h0000_0108);
    wait_idle();
    chk("R9 no trailing skip", madr_rd, 32'h0000_00C0);

    // R8 N=0 in interleave mode is linear
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd4);
    wr(2'd3, 32'h0000_0003);
    wr(2'd0, 32'h0000_0108);
    wait_idle();
    chk("R8 zero group linear", madr_rd, 32'h0000_0040);

    // R8 chain mode is linear
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd4);
    wr(2'd3, 32'h0002_0003);
    wr(2'd0, 32'h0000_0104);
    wait_idle();
    chk("R8 other mode linear", madr_rd, 32'h0000_0040);

    // R10 writes ignored while busy
    rdy_rand = 1'b0; rdy_fix = 1'b0;
    wr(2'd1, 32'h0000_0200);
    wr(2'd2, 32'd10);
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, 32'h0000_9990);
    wr(2'd2, 32'd3);
    wr(2'd3, 32'h0005_0005);
    wr(2'd0, 32'h0000_0108);
    chk("R10 addr kept", madr_rd, 32'h0000_0200);
    chk("R10 count kept", {16'd0, qwc_rd}, 32'd10);
    chk("R10 skip kept", sqwc_rd, 32'h0002_0003);
    chk("R10 ctrl kept", ctrl_rd, 32'h0000_0100);
    chk("R4 stalled addr", addr_data, 32'h0000_0200);
    rdy_fix = 1'b1;
    wait_idle();
    chk("R10 end", madr_rd, 32'h0000_02A0);

    // R11 wrap inside bits 30:4
    wr(2'd1, 32'hFFFF_FFF0);
    wr(2'd2, 32'd2);
    wr(2'd0, 32'h0000_0100);
    wait_idle();
    chk("R11 wrap", madr_rd, 32'h8000_0010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule